// File: doc/BRIEF.md
# Locality Claim and Release Controller

This block is a host-side sequencer that takes ownership of, and later gives back, locality 0 of a memory-mapped trusted-module register interface. It talks to the module through a simple register master port. A request is held on the port until the slave acknowledges it, and read data returns together with the acknowledge.

An open pulse starts the claim. The controller writes the request-use value to the access register and polls that register until the active-locality bit reads as set. It then writes the command-ready value to the status register. A close pulse starts the release. The controller first reads the access register. If the locality is active, it writes the active bit back to give the locality up and polls until the bit reads as clear. If the locality is not active, it finishes at once.

Each poll is paced by a microsecond-style tick from a prescaler. A poll gives up after a parameterised number of unsuccessful reads. Every operation ends with a one-cycle done pulse and a two-bit result code.

Top module: `loc_claim_ctrl`

## Requirements
- R1: After reset, `bus_req`, `done` and `result` are all 0.
- R2: An open pulse in idle causes a write of 0x02 (request-use, bit 1) to `ACCESS_ADDR`. Reads of `ACCESS_ADDR` follow until bit 5 (active-locality) reads as 1.
- R3: Once bit 5 reads as 1 during a claim, one write of 0x40 (command-ready) goes to `STATUS_ADDR`. After it is acknowledged, `done` pulses with `result` = 2'b00 (ok).
- R4: If `POLL_LIMIT` consecutive claim reads all show bit 5 clear, `done` pulses with `result` = 2'b01 (claim timeout). In that case no read beyond the limit is made and no status write is made.
- R5: Between two reads of one poll, the next read waits for a prescaler tick. Successive reads in a poll are at most `TICK_DIV`+1 cycles apart, acknowledge to acknowledge. From the third read on, they are exactly `TICK_DIV` cycles apart.
- R6: A close pulse in idle causes one read of `ACCESS_ADDR`. If bit 5 is set, the controller writes 0x20 to `ACCESS_ADDR`, then polls until bit 5 reads as 0, then pulses `done` with `result` = 2'b00.
- R7: If that first close read shows bit 5 clear, no write is made and `done` pulses with `result` = 2'b00 after that single read.
- R8: If `POLL_LIMIT` consecutive release poll reads all show bit 5 set, `done` pulses with `result` = 2'b10 (release timeout).
- R9: Open and close pulses that arrive while an operation is in progress are ignored. If both arrive together in idle, open wins.
- R10: `done` lasts exactly one cycle. `result` changes only in the cycle where `done` is high, and holds its value until the next done pulse.
- R11: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| open_req | input | 1 | Pulse: claim locality 0 |
| close_req | input | 1 | Pulse: release locality 0 |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 ok, 01 claim timeout, 10 release timeout |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Register byte address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Access completed; read data valid |
| bus_rdata | input | DATA_W | Read data |

## Verification
The bench builds the block with `TICK_DIV` = 4 and `POLL_LIMIT` = 5, so both timeouts are reached within a few dozen cycles. It sweeps the number of refused claim polls and of refused release polls from 0 to 6, which covers every count below the limit, the count one short of it, the count equal to it and the count beyond it. The reference register model answers with a programmable number of refusals, so the bench can predict the number of reads, the writes, the result code and the tick spacing of the poll reads arithmetically.

// File: rtl/loc_pkg.sv
package loc_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLM_WR,
        ST_CLM_RD,
        ST_CLM_WAIT,
        ST_CMD_WR,
        ST_REL_CHK,
        ST_REL_WR,
        ST_REL_RD,
        ST_REL_WAIT
    } loc_state_e;

    localparam logic [1:0] RES_OK      = 2'b00;
    localparam logic [1:0] RES_CLM_TO  = 2'b01;
    localparam logic [1:0] RES_REL_TO  = 2'b10;

    localparam int unsigned ACT_BIT     = 5;
    localparam logic [7:0]  VAL_REQ_USE = 8'h02;
    localparam logic [7:0]  VAL_ACTIVE  = 8'h20;
    localparam logic [7:0]  VAL_CMD_RDY = 8'h40;
endpackage

// File: rtl/loc_tick_gen.sv
module loc_tick_gen #(
    parameter int unsigned TICK_DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == TW'(TICK_DIV - 1)) cnt_d = '0;
        else                             cnt_d = cnt_q + 1'b1;
        tick = (cnt_q == TW'(TICK_DIV - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/loc_poll_eval.sv
module loc_poll_eval #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned POLL_LIMIT = 16
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic              want_set,
    input  logic [CNT_W-1:0]  fails,
    output logic              hit,
    output logic              expire
);
    always_comb begin
        hit    = (rdata[loc_pkg::ACT_BIT] == want_set);
        expire = (fails == CNT_W'(POLL_LIMIT - 1));
    end
endmodule

// File: rtl/loc_claim_ctrl.sv
module loc_claim_ctrl #(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned TICK_DIV    = 100,
    parameter int unsigned POLL_LIMIT  = 1000000,
    parameter logic [15:0] ACCESS_ADDR = 16'h0000,
    parameter logic [15:0] STATUS_ADDR = 16'h0018
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_req,
    input  logic              close_req,
    output logic              done,
    output logic [1:0]        result,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    import loc_pkg::*;

    localparam int unsigned CNT_W = $clog2(POLL_LIMIT + 1);
    localparam logic [ADDR_W-1:0] A_ACC = ADDR_W'(ACCESS_ADDR);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(STATUS_ADDR);

    typedef struct packed {
        loc_state_e        st;
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [CNT_W-1:0]  fails;
        logic              done;
        logic [1:0]        res;
    } ctrl_t;

    ctrl_t n_d, n_q;
    logic  tick, hit, expire, want_set;

    loc_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    assign want_set = (n_q.st == ST_CLM_RD);

    loc_poll_eval #(.DATA_W(DATA_W), .CNT_W(CNT_W), .POLL_LIMIT(POLL_LIMIT)) i_eval (
        .rdata   (bus_rdata),
        .want_set(want_set),
        .fails   (n_q.fails),
        .hit     (hit),
        .expire  (expire)
    );

    always_comb begin
        n_d      = n_q;
        n_d.done = 1'b0;
        unique case (n_q.st)
            ST_IDLE: begin
                if (open_req) begin
                    n_d.st = ST_CLM_WR; n_d.req = 1'b1; n_d.we = 1'b1;
                    n_d.addr = A_ACC; n_d.wdata = DATA_W'(VAL_REQ_USE);
                end else if (close_req) begin
                    n_d.st = ST_REL_CHK; n_d.req = 1'b1; n_d.we = 1'b0;
                    n_d.addr = A_ACC; n_d.wdata = '0;
                end
            end
            ST_CLM_WR, ST_REL_WR: if (bus_ack) begin
                n_d.st    = (n_q.st == ST_CLM_WR) ? ST_CLM_RD : ST_REL_RD;
                n_d.we    = 1'b0;
                n_d.wdata = '0;
                n_d.fails = '0;
            end
            ST_CLM_RD, ST_REL_RD: if (bus_ack) begin
                if (hit && n_q.st == ST_CLM_RD) begin
                    n_d.st = ST_CMD_WR; n_d.we = 1'b1;
                    n_d.addr = A_STS; n_d.wdata = DATA_W'(VAL_CMD_RDY);
                end else if (hit) begin
                    n_d.st = ST_IDLE; n_d.req = 1'b0;
                    n_d.done = 1'b1; n_d.res = RES_OK;
                end else if (expire) begin
                    n_d.st = ST_IDLE; n_d.req = 1'b0; n_d.done = 1'b1;
                    n_d.res = (n_q.st == ST_CLM_RD) ? RES_CLM_TO : RES_REL_TO;
                end else begin
                    n_d.st    = (n_q.st == ST_CLM_RD) ? ST_CLM_WAIT : ST_REL_WAIT;
                    n_d.req   = 1'b0;
                    n_d.fails = n_q.fails + 1'b1;
                end
            end
            ST_CLM_WAIT, ST_REL_WAIT: if (tick) begin
                n_d.st  = (n_q.st == ST_CLM_WAIT) ? ST_CLM_RD : ST_REL_RD;
                n_d.req = 1'b1;
            end
            ST_CMD_WR: if (bus_ack) begin
                n_d.st = ST_IDLE; n_d.req = 1'b0; n_d.we = 1'b0;
                n_d.wdata = '0; n_d.done = 1'b1; n_d.res = RES_OK;
            end
            ST_REL_CHK: if (bus_ack) begin
                if (bus_rdata[ACT_BIT]) begin
                    n_d.st = ST_REL_WR; n_d.we = 1'b1;
                    n_d.wdata = DATA_W'(VAL_ACTIVE);
                end else begin
                    n_d.st = ST_IDLE; n_d.req = 1'b0;
                    n_d.done = 1'b1; n_d.res = RES_OK;
                end
            end
            default: n_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q       <= '0;
            n_q.st    <= ST_IDLE;
        end else begin
            n_q <= n_d;
        end
    end

    assign done      = n_q.done;
    assign result    = n_q.res;
    assign bus_req   = n_q.req;
    assign bus_we    = n_q.we;
    assign bus_addr  = n_q.addr;
    assign bus_wdata = n_q.wdata;
endmodule

// File: rtl/loc_claim_ctrl_chk.sv
module loc_claim_ctrl_chk #(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 32,
    parameter logic [15:0] ACCESS_ADDR = 16'h0000,
    parameter logic [15:0] STATUS_ADDR = 16'h0018
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [1:0]        result,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack
);
    p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    p_result_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> result != 2'b11);

    p_access_wdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == ADDR_W'(ACCESS_ADDR)
        |-> bus_wdata == DATA_W'(8'h02) || bus_wdata == DATA_W'(8'h20));

    p_status_wdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == ADDR_W'(STATUS_ADDR) |-> bus_wdata == DATA_W'(8'h40));

    p_no_status_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we |-> bus_addr == ADDR_W'(ACCESS_ADDR));
endmodule

bind loc_claim_ctrl loc_claim_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ACCESS_ADDR(ACCESS_ADDR), .STATUS_ADDR(STATUS_ADDR)
) i_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .result(result),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/test_loc_claim_ctrl.sv
module test_loc_claim_ctrl;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned TDIV   = 4;
    localparam int unsigned LIMIT  = 5;
    localparam logic [15:0] A_ACC  = 16'h0000;
    localparam logic [15:0] A_STS  = 16'h0018;

    logic clk = 1'b0, rst_n = 1'b0, open_req = 1'b0, close_req = 1'b0;
    logic done, bus_req, bus_we, bus_ack = 1'b0;
    logic [1:0] result;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata, bus_rdata = '0;

    int n_cmp = 0, n_bad = 0, cyc = 0, done_cnt = 0;
    // register model state
    logic active = 1'b0, clm_pend = 1'b0, rel_pend = 1'b0, prev_rd = 1'b0;
    int clm_rem = 0, rel_rem = 0, cfg_clm = 0, cfg_rel = 0;
    int n_rd = 0, n_wr_req = 0, n_wr_rel = 0, n_wr_sts = 0, n_wr_bad = 0;
    int last_ack = 0, first_gap = 0, last_gap = 0, n_gap = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) if (rst_n && done) done_cnt <= done_cnt + 1;

    loc_claim_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TICK_DIV(TDIV), .POLL_LIMIT(LIMIT),
        .ACCESS_ADDR(A_ACC), .STATUS_ADDR(A_STS)
    ) i_loc_claim_ctrl (
        .clk(clk), .rst_n(rst_n), .open_req(open_req), .close_req(close_req),
        .done(done), .result(result), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic slave_loop();
        forever begin
            @(posedge clk);
            #1;
            if (bus_req && !bus_ack) begin
                bus_ack = 1'b1;
                if (!bus_we && bus_addr == ADDR_W'(A_ACC)) begin
                    if (clm_pend) begin
                        if (clm_rem == 0) begin active = 1'b1; clm_pend = 1'b0; end
                        else clm_rem--;
                    end else if (rel_pend) begin
                        if (rel_rem == 0) begin active = 1'b0; rel_pend = 1'b0; end
                        else rel_rem--;
                    end
                    bus_rdata = DATA_W'({1'b1, 1'b0, active, 5'b0});
                    n_rd++;
                    if (prev_rd) begin
                        n_gap++;
                        last_gap = cyc - last_ack;
                        if (n_gap == 1) first_gap = last_gap;
                    end
                    prev_rd = 1'b1;
                end else begin
                    prev_rd = 1'b0;
                    bus_rdata = '0;
                    if (bus_we && bus_addr == ADDR_W'(A_ACC) && bus_wdata == 32'h02) begin
                        n_wr_req++; clm_pend = 1'b1; clm_rem = cfg_clm;
                    end else if (bus_we && bus_addr == ADDR_W'(A_ACC) && bus_wdata == 32'h20) begin
                        n_wr_rel++; rel_pend = 1'b1; rel_rem = cfg_rel;
                    end else if (bus_we && bus_addr == ADDR_W'(A_STS) && bus_wdata == 32'h40) begin
                        n_wr_sts++;
                    end else n_wr_bad++;
                end
                last_ack = cyc;
            end else begin
                bus_ack = 1'b0;
            end
        end
    endtask

    task automatic clr_stats();
        n_rd = 0; n_wr_req = 0; n_wr_rel = 0; n_wr_sts = 0; n_wr_bad = 0;
        n_gap = 0; first_gap = 0; last_gap = 0; prev_rd = 1'b0;
        clm_pend = 1'b0; rel_pend = 1'b0;
    endtask

    // pulse request(s) and wait for done; returns result and done count
    task automatic run_op(input logic op, input logic cl, output int res, output int dn);
        int d0;
        d0 = done_cnt;
        @(negedge clk);
        open_req = op; close_req = cl;
        @(negedge clk);
        open_req = 1'b0; close_req = 1'b0;
        res = -1;
        for (int i = 0; i < 400; i++) begin
            if (done) begin res = int'(result); break; end
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
        dn = done_cnt - d0;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int res, dn, r_old;
        fork slave_loop(); join_none
        repeat (3) @(negedge clk);
        chk("R1 bus_req", int'(bus_req), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 result", int'(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // claim sweep: N refused polls
        for (int n = 0; n <= LIMIT + 1; n++) begin
            active = 1'b0; cfg_clm = n; clr_stats();
            run_op(1'b1, 1'b0, res, dn);
            chk($sformatf("R2 req-use writes n=%0d", n), n_wr_req, 1);
            chk($sformatf("R2 poll reads n=%0d", n), n_rd, (n < LIMIT) ? n + 1 : LIMIT);
            chk($sformatf("R3 status write n=%0d", n), n_wr_sts, (n < LIMIT) ? 1 : 0);
            chk($sformatf("R4 result n=%0d", n), res, (n < LIMIT) ? 0 : 1);
            chk($sformatf("R10 one done n=%0d", n), dn, 1);
            chk($sformatf("R2 bad writes n=%0d", n), n_wr_bad, 0);
            if (n_rd >= 2)
                chk($sformatf("R5 first gap in range n=%0d", n),
                    int'(first_gap >= 2 && first_gap <= TDIV + 1), 1);
            if (n_rd >= 3)
                chk($sformatf("R5 steady gap n=%0d", n), last_gap, TDIV);
        end

        // release sweep: M refused polls, starting active
        for (int m = 0; m <= LIMIT + 1; m++) begin
            active = 1'b1; cfg_rel = m; clr_stats();
            run_op(1'b0, 1'b1, res, dn);
            chk($sformatf("R6 release writes m=%0d", m), n_wr_rel, 1);
            chk($sformatf("R6 reads m=%0d", m), n_rd, 1 + ((m < LIMIT) ? m + 1 : LIMIT));
            chk($sformatf("R8 result m=%0d", m), res, (m < LIMIT) ? 0 : 2);
            chk($sformatf("R6 no claim writes m=%0d", m), n_wr_req + n_wr_sts + n_wr_bad, 0);
            if (n_rd >= 4)
                chk($sformatf("R5 release steady gap m=%0d", m), last_gap, TDIV);
        end

        // release when inactive
        active = 1'b0; clr_stats();
        run_op(1'b0, 1'b1, res, dn);
        chk("R7 single read", n_rd, 1);
        chk("R7 no writes", n_wr_req + n_wr_rel + n_wr_sts + n_wr_bad, 0);
        chk("R7 result ok", res, 0);
        chk("R7 one done", dn, 1);

        // result hold after a timeout, then change on next done
        active = 1'b1; cfg_rel = LIMIT + 3; clr_stats();
        run_op(1'b0, 1'b1, res, dn);
        r_old = int'(result);
        repeat (10) @(negedge clk);
        chk("R10 result held", int'(result), 2);
        chk("R10 result held same", int'(result), r_old);

        // both at once: open wins
        active = 1'b0; cfg_clm = 1; clr_stats();
        run_op(1'b1, 1'b1, res, dn);
        chk("R9 open priority req-use", n_wr_req, 1);
        chk("R9 open priority release", n_wr_rel, 0);
        chk("R9 open priority result", res, 0);

        // requests while busy are ignored
        active = 1'b0; cfg_clm = 3; clr_stats();
        @(negedge clk); open_req = 1'b1;
        @(negedge clk); open_req = 1'b0;
        repeat (3) @(negedge clk); close_req = 1'b1;
        @(negedge clk); close_req = 1'b0;
        repeat (2) @(negedge clk); open_req = 1'b1;
        @(negedge clk); open_req = 1'b0;
        repeat (80) @(negedge clk);
        chk("R9 busy one req-use write", n_wr_req, 1);
        chk("R9 busy no release write", n_wr_rel, 0);
        chk("R9 busy reads", n_rd, 4);
        chk("R9 busy status writes", n_wr_sts, 1);
        chk("R11 no malformed writes", n_wr_bad, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule